// File: doc/BRIEF.md
# Dual-Mode LFSR Pixel Counter

This block is the per-pixel digital store of a pulse-frequency image sensor. A light-to-frequency converter produces a pulse train whose rate follows the local light level. The block counts those pulses in a 10-stage pseudo-random shift register with XNOR feedback. Once the exposure has ended, the same register chain becomes a plain serial shift path. Its contents leave through a serial output while bits from a neighbouring pixel enter at the serial input, so pixels can be daisy-chained into columns with no separate readout logic.

A single frame control line sets the timing. Its high-to-low transition starts an exposure and clears the register to zero. While it stays low, each converter pulse advances the register by one step. While it is high, the register shifts by one place on every system clock in which the shift enable is high. The register counts in a pseudo-random order rather than in binary, so an off-pixel decoder maps each final state back to a pulse count. The pulse input is asynchronous. A synchroniser and an edge detector turn each pulse into one count step in the system clock domain.

Top module: `pixel_lfsr_counter`

## Requirements
- R1: After reset the register holds all zeros, and `ser_out` is 0.
- R2: In the clock cycle where `frame_ctl` is first seen low after being high, the register is cleared to all zeros. This happens whatever it held before, including an all-ones pattern shifted in during readout.
- R3: In count mode, a step moves every stage up by one: stage k takes the value of stage k-1, with stage 1 as bit 0 and stage 10 as bit 9. Stage 1 takes the XNOR of stage 10 and stage 7. After n steps from zero the register holds the n-th state of that sequence.
- R4: `pulse_in` passes through a two-flop synchroniser and a rising-edge detector. Each low-to-high transition gives exactly one count step, whatever its width, provided the input stays high for at least two clocks and low for at least two clocks.
- R5: Counting saturates. Once the register holds the 1022nd state (the state whose successor would be all zeros), further pulses leave it unchanged. A frame with more than 1022 pulses therefore decodes to 1022.
- R6: With `frame_ctl` high and `shift_en` high, each clock moves the register one stage toward stage 10 and loads `ser_in` into stage 1. `ser_out` always shows stage 10, so a readout delivers the most significant bit first. After 10 shifts, the register holds the 10 bits that were fed in, with the first one fed sitting in stage 10.
- R7: With `frame_ctl` high and `shift_en` low, the register holds its value, and pulses on `pulse_in` have no effect on it.
- R8: While `frame_ctl` is low, `shift_en` and `ser_in` have no effect on the count.
- R9: During counting that started from the cleared state, the register never holds all ones (the lock-up state of XNOR feedback).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous pulse train from the light-to-frequency converter |
| frame_ctl | input | 1 | Low = exposure (count mode); high = readout/idle (shift mode) |
| shift_en | input | 1 | Shift one place per clock while `frame_ctl` is high |
| ser_in | input | 1 | Serial bit from the neighbouring pixel, loaded into stage 1 |
| ser_out | output | 1 | Serial bit to the next pixel, always stage 10 |

## Verification
The bench builds the block with its default parameters: width 10, taps at stages 10 and 7, a two-stage synchroniser, and saturation enabled. These values make the full 1023-state sequence short enough to walk end to end, so the saturation point at 1022 is reached in a single frame of 1030 pulses. The bench decodes each readout with a state-to-count table built from its own model of the taps. It then drives the cases that separate the modes: shift noise during exposure, pulses while readout is paused, an all-ones pattern fed in through the daisy chain and followed by a fresh exposure, and pulses of different widths.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  localparam int PXC_MAXW = 32;

  typedef enum logic [1:0] {
    PXC_IDLE  = 2'd0,
    PXC_LOAD  = 2'd1,
    PXC_COUNT = 2'd2,
    PXC_SHIFT = 2'd3
  } pxc_op_e;

  // Successor of a Fibonacci state: every stage moves up one place, and
  // stage 1 receives XNOR of the two tap stages (taps numbered from 1).
  function automatic logic [PXC_MAXW-1:0] lfsr_succ(
      input logic [PXC_MAXW-1:0] cur, input int width,
      input int tap_hi, input int tap_lo);
    logic                fb;
    logic [PXC_MAXW-1:0] keep;
    fb   = ~(cur[tap_hi-1] ^ cur[tap_lo-1]);
    keep = (PXC_MAXW'(1) << width) - PXC_MAXW'(1);
    return ((cur << 1) | PXC_MAXW'(fb)) & keep;
  endfunction

  // The last state of the maximal sequence is the one whose successor
  // is the all-zero start state.
  function automatic logic is_terminal(
      input logic [PXC_MAXW-1:0] cur, input int width,
      input int tap_hi, input int tap_lo);
    return lfsr_succ(cur, width, tap_hi, tap_lo) == '0;
  endfunction

endpackage

// File: rtl/pxc_pulse_sync.sv
module pxc_pulse_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_async,
  output logic rise_evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pulse_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_evt = sync_q[LAST] & ~prev_q;

  // R4: one detected edge gives a single-cycle event
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

endmodule

// File: rtl/pxc_mode_ctrl.sv
module pxc_mode_ctrl
  import pxc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_ctl,
  input  logic    shift_en,
  input  logic    count_evt,
  output pxc_op_e op,
  output logic    count_live
);
  logic frame_q;
  logic start_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_ctl;
  end

  assign start_fall = frame_q & ~frame_ctl;
  assign count_live = ~frame_q & ~frame_ctl;

  always_comb begin
    op = PXC_IDLE;
    if (start_fall)              op = PXC_LOAD;
    else if (!frame_ctl)         op = count_evt ? PXC_COUNT : PXC_IDLE;
    else if (shift_en)           op = PXC_SHIFT;
  end

  // R2: the clear happens once per exposure start
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PXC_LOAD) |=> (op != PXC_LOAD));

  // R8: no shifting while exposing
  a_r8_no_shift_in_exposure: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ctl |-> (op != PXC_SHIFT));

endmodule

// File: rtl/pxc_shift_chain.sv
module pxc_shift_chain
  import pxc_pkg::*;
#(
  parameter int WIDTH    = 10,
  parameter int TAP_HI   = 10,
  parameter int TAP_LO   = 7,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pxc_op_e          op,
  input  logic             ser_in,
  input  logic             count_live,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] succ;
  logic             at_terminal;
  logic             hold_top;
  logic             first_in;
  logic [WIDTH-1:0] state_d;

  assign succ        = WIDTH'(lfsr_succ(PXC_MAXW'(state_q), WIDTH, TAP_HI, TAP_LO));
  assign at_terminal = is_terminal(PXC_MAXW'(state_q), WIDTH, TAP_HI, TAP_LO);

  generate
    if (SATURATE) begin : g_sat
      assign hold_top = at_terminal;
    end else begin : g_wrap
      assign hold_top = 1'b0;
    end
  endgenerate

  // Stage-1 input multiplexer: feedback in count mode, neighbour bit in shift mode.
  assign first_in = (op == PXC_SHIFT) ? ser_in : succ[0];

  always_comb begin
    state_d = state_q;
    unique case (op)
      PXC_LOAD:  state_d = '0;
      PXC_COUNT: if (!hold_top) state_d = {state_q[WIDTH-2:0], first_in};
      PXC_SHIFT: state_d = {state_q[WIDTH-2:0], first_in};
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: exposure start clears the chain
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PXC_LOAD) |=> (state_q == '0));

  // R3: a count step away from the end always moves the state
  a_r3_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PXC_COUNT && !at_terminal) |=> (state_q != $past(state_q)));

  // R5: saturation holds the terminal state
  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && op == PXC_COUNT && at_terminal) |=> $stable(state_q));

  // R6: shift moves serial data in at stage 1 and up one place
  a_r6_shift_path: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PXC_SHIFT) |=> (state_q[0] == $past(ser_in)) &&
                          (state_q[WIDTH-1] == $past(state_q[WIDTH-2])));

  // R7: idle leaves the chain alone
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PXC_IDLE) |=> $stable(state_q));

  // R9: no lock-up state while counting from the cleared start
  a_r9_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    count_live |-> (state_q != ALL_ONES));

endmodule

// File: rtl/pixel_lfsr_counter.sv
module pixel_lfsr_counter
  import pxc_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter int TAP_HI      = 10,
  parameter int TAP_LO      = 7,
  parameter int SYNC_STAGES = 2,
  parameter bit SATURATE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic frame_ctl,
  input  logic shift_en,
  input  logic ser_in,
  output logic ser_out
);
  localparam int MSB = WIDTH - 1;

  logic             count_evt;
  logic             count_live;
  pxc_op_e          op;
  logic [WIDTH-1:0] chain_state;

  pxc_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_async(pulse_in),
    .rise_evt   (count_evt)
  );

  pxc_mode_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_ctl (frame_ctl),
    .shift_en  (shift_en),
    .count_evt (count_evt),
    .op        (op),
    .count_live(count_live)
  );

  pxc_shift_chain #(
    .WIDTH   (WIDTH),
    .TAP_HI  (TAP_HI),
    .TAP_LO  (TAP_LO),
    .SATURATE(SATURATE)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .ser_in    (ser_in),
    .count_live(count_live),
    .state_o   (chain_state)
  );

  assign ser_out = chain_state[MSB];

  // R7: with readout paused the serial output does not change
  a_r7_ser_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ctl && $past(frame_ctl) && !$past(shift_en)) |-> $stable(ser_out));

endmodule

// File: tb/sim_pixel_lfsr_counter.sv
module sim_pixel_lfsr_counter;
  localparam int W    = 10;
  localparam int NST  = 1 << W;
  localparam int TOP  = NST - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic frame_ctl = 1'b1;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int               cnt_of_state [NST];
  logic [W-1:0]     state_of_cnt [NST];
  logic [W-1:0]     exp_q[$];
  string            tag_q[$];

  always #10 clk = ~clk;

  pixel_lfsr_counter u0 (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .frame_ctl(frame_ctl),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out)
  );

  // Reference model: R3 sequence, stage 1 gets XNOR(stage 10, stage 7).
  function automatic logic [W-1:0] ref_next(logic [W-1:0] s);
    logic nb;
    nb = (s[9] == s[6]);
    return {s[8:0], nb};
  endfunction

  task automatic build_table();
    logic [W-1:0] s = '0;
    for (int i = 0; i < NST; i++) cnt_of_state[i] = -1;
    for (int i = 0; i < NST - 1; i++) begin
      state_of_cnt[i] = s;
      cnt_of_state[s] = i;
      s = ref_next(s);
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic one_pulse(int hi, int lo, bit noise);
    for (int k = 0; k < hi; k++) begin
      @(negedge clk);
      pulse_in = 1'b1;
      if (noise) begin shift_en = ~shift_en; ser_in = ~ser_in; end
    end
    for (int k = 0; k < lo; k++) begin
      @(negedge clk);
      pulse_in = 1'b0;
      if (noise) begin shift_en = ~shift_en; ser_in = ~ser_in; end
    end
  endtask

  task automatic read_out(logic [W-1:0] pat);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      shift_en = 1'b1;
      ser_in   = pat[W-1-i];
    end
    @(negedge clk);
    shift_en = 1'b0;
    ser_in   = 1'b0;
  endtask

  // Driver: one exposure, expected state pushed, then readout.
  task automatic run_frame(int n, int hi, int lo, bit noise, string tag);
    int capped;
    @(negedge clk);
    frame_ctl = 1'b0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < n; p++) one_pulse(hi, lo, noise);
    shift_en = 1'b0;
    ser_in   = 1'b0;
    repeat (4) @(negedge clk);
    frame_ctl = 1'b1;
    repeat (2) @(negedge clk);
    capped = (n > TOP) ? TOP : n;
    exp_q.push_back(state_of_cnt[capped]);
    tag_q.push_back(tag);
  endtask

  // Monitor: collects serial bits MSB first and compares with the queue.
  initial begin
    logic [W-1:0] word = '0;
    int nbits = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && frame_ctl && shift_en) begin
        word = {word[W-2:0], ser_out};
        nbits++;
        if (nbits == W) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected readout", int'(word), -1);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(word == e, t, "readout state", int'(word), int'(e));
            if (t != "R6") begin
              check(word != {W{1'b1}}, "R9", "lock-up state seen",
                    int'(word), cnt_of_state[e]);
              check(cnt_of_state[word] == cnt_of_state[e], t, "decoded count",
                    cnt_of_state[word], cnt_of_state[e]);
            end
          end
        end
      end
    end
  end

  initial begin
    build_table();
    repeat (3) @(negedge clk);
    #1;
    check(ser_out == 1'b0, "R1", "ser_out after reset", int'(ser_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset contents read out as zero
    exp_q.push_back('0); tag_q.push_back("R1");
    read_out('0);

    run_frame(1,  3, 3, 1'b0, "R3");
    read_out('0);
    run_frame(37, 3, 3, 1'b0, "R3");
    read_out('0);
    // R8: shift_en and ser_in toggling during exposure
    run_frame(21, 3, 3, 1'b1, "R8");
    read_out('0);
    // R4: wide and narrow pulses
    run_frame(300, 7, 2, 1'b0, "R4");
    read_out('0);
    run_frame(12, 2, 9, 1'b0, "R4");
    read_out('0);
    // R5: saturation past the end of the sequence
    run_frame(1030, 3, 3, 1'b0, "R5");
    read_out('0);

    // R7: pulses while readout is paused are ignored
    run_frame(5, 3, 3, 1'b0, "R7");
    for (int p = 0; p < 4; p++) one_pulse(3, 3, 1'b0);
    repeat (5) @(negedge clk);
    #1;
    check(ser_out == state_of_cnt[5][W-1], "R7", "ser_out held while paused",
          int'(ser_out), int'(state_of_cnt[5][W-1]));
    // R6: feed a pattern in through the chain, then read it back
    read_out(10'h2B5);
    exp_q.push_back(10'h2B5); tag_q.push_back("R6");
    read_out(10'h3FF);
    // register now holds all ones (R6); next exposure must clear it (R2)
    exp_q.push_back(10'h3FF); tag_q.push_back("R6");
    read_out(10'h3FF);
    run_frame(0, 3, 3, 1'b0, "R2");
    read_out(10'h3FF);
    run_frame(3, 3, 3, 1'b0, "R2");
    read_out('0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending readouts", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule